// File: doc/BRIEF.md
# Target CPU Bus Ownership Controller

This controller takes the external bus of an 8-bit target CPU away from it and gives it back. It also owns that CPU's reset line. A host issues one-cycle commands: Reset, Request, Release, Run, Restart and M-cycle. The controller then runs a timed sequence on three signals: the active-low bus request, the sampled active-low bus acknowledge, and the reset line. It also switches the enable of the address and strobe drivers. The drivers are enabled only while the bus is held. The strobe levels behind the enable stay at their inactive-high preset.

Bus ownership and CPU reset share a single four-state machine. The current state decides whether a grant or a release also asserts reset or pulses it. Every wait for the acknowledge to change is bounded by a timeout, counted in ticks of a slow free-running timebase. The active level of the reset line is not fixed. On the first clock after its own reset, the block reads the level present on the line and takes it as the active level from then on.

A busy flag is high while any timed sequence runs. Commands that arrive while busy are dropped.

Top module: `cpu_bus_owner`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, the outputs are: `busy`=1, `rstOe`=0, `busReqN`=1, `addrOe`=0, `busState`=0. From the second cycle on, `rstOe`=1, `busy`=0, and the reset line is driven at its active level.
- R2: The `busState` encoding is 0 = in reset, bus free; 1 = in reset, bus held; 2 = running, bus free; 3 = running, bus held. `acquired` is bit 0 of `busState`. Whenever `busy` is low, `addrOe` equals `acquired`.
- R3: Command codes are Reset=0, Request=1, Release=2, Run=3, Restart=4, M-cycle=5. Request in state 0 pulls `busReqN` low and releases reset on the accepting edge. A low `ackN` then enables the drivers and gives state 1.
- R4: If `ackN` stays high, Request in state 0 ends after the timeout. The timeout is TIMEOUT_TICKS ticks of the tick timebase, so it lasts between (TIMEOUT_TICKS-1) and TIMEOUT_TICKS tick periods. The block then reasserts reset, drops the request and stays in state 0.
- R5: Request in state 2 leaves reset untouched. It goes to state 3 on a grant. On a timeout it drops the request and stays in state 2.
- R6: Release in state 1 disables the drivers and asserts reset at once. It holds the request for exactly the reset pulse width, drops it, waits for `ackN` high or the timeout, and ends in state 0.
- R7: Release in state 3 disables the drivers and drops the request on the same edge. Reset stays inactive, and the block ends in state 2.
- R8: Run in state 0 keeps reset active for the run delay (busy for exactly that many cycles), then releases it and enters state 2.
- R9: Run in state 1 disables the drivers during a reset pulse of exactly the pulse width. It then re-enables them and enters state 3.
- R10: Restart in state 2 or 3 gives a reset pulse of exactly the pulse width. The state and the driver enable are unchanged afterwards.
- R11: M-cycle in state 3 disables the drivers and drops the request until `ackN` goes high, then asks again. A new grant restores state 3 with the drivers on. A regrant timeout leaves state 2.
- R12: Reset from any idle state ends in state 0 with reset active, `busReqN`=1 and `addrOe`=0.
- R13: A command is ignored, with no busy cycle and no output change, in these cases: it arrives while busy, it is not defined for the current state, or its code is 6 or 7.
- R14: The level sampled on `rstSense` in the first cycle after reset becomes the active reset level. Every later assertion of reset drives that level, and every release drives its inverse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| cmdValid | input | 1 | One-cycle command strobe |
| cmdCode | input | 3 | Command code (R3) |
| ackN | input | 1 | Target bus acknowledge, active low |
| rstSense | input | 1 | Level read back from the target reset line |
| busReqN | output | 1 | Target bus request, active low |
| rstDrive | output | 1 | Level driven onto the target reset line |
| rstOe | output | 1 | Output enable for the reset line driver |
| addrOe | output | 1 | Enable for the address and strobe drivers |
| busState | output | 2 | Current ownership state (R2) |
| acquired | output | 1 | Bus held flag |
| busy | output | 1 | A timed sequence is running |

## Verification
Two things can meet in a single cycle: the last cycle of a timed wait, and the arrival of a new command. The bench starts a Run delay and pulses a Request exactly in the final busy cycle. It then checks that the Run completes and that the Request left no trace: the state is still 2 and the request is still high. Random command streams run against an acknowledge model that either follows the request with a two-cycle lag or never grants. After each sequence, the state, the driver enable and the reset level are compared with a reference table.

// File: rtl/cpu_bus_owner_pkg.sv
package cpu_bus_owner_pkg;

  typedef enum logic [1:0] {
    ST_RESET    = 2'd0,
    ST_RESET_ACQ = 2'd1,
    ST_RUN      = 2'd2,
    ST_RUN_ACQ  = 2'd3
  } busState_t;

  typedef enum logic [2:0] {
    CMD_RESET   = 3'd0,
    CMD_REQUEST = 3'd1,
    CMD_RELEASE = 3'd2,
    CMD_RUN     = 3'd3,
    CMD_RESTART = 3'd4,
    CMD_MCYCLE  = 3'd5
  } busCmd_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capturePol;
    logic setReq;
    logic clrReq;
    logic setRst;
    logic clrRst;
    logic setOe;
    logic clrOe;
    logic loadPulse;
    logic loadRun;
    logic loadTimeout;
  } dpCtl_t;

endpackage

// File: rtl/cpu_bus_owner_dp.sv
module cpu_bus_owner_dp
  import cpu_bus_owner_pkg::*;
#(
  parameter int PULSE_CYC     = 500,
  parameter int RUN_CYC       = 1000000,
  parameter int TICK_CYC      = 5000000,
  parameter int TIMEOUT_TICKS = 20
) (
  input  logic   clk,
  input  logic   rstN,
  input  dpCtl_t ctl,
  input  logic   rstSense,
  output logic   busReqN,
  output logic   rstDrive,
  output logic   rstOe,
  output logic   addrOe,
  output logic   delayDone,
  output logic   timeoutDone
);

  localparam int MAX_DLY = (PULSE_CYC > RUN_CYC) ? PULSE_CYC : RUN_CYC;
  localparam int DLY_W   = $clog2(MAX_DLY + 1);
  localparam int PRE_W   = $clog2(TICK_CYC + 1);
  localparam int TO_W    = $clog2(TIMEOUT_TICKS + 1);

  logic             reqOn, rstOn, oeOn, polReg, polKnown;
  logic [DLY_W-1:0] dlyCnt;
  logic [PRE_W-1:0] preCnt;
  logic [TO_W-1:0]  toCnt;
  logic             tick;

  assign tick = (preCnt == PRE_W'(TICK_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqOn    <= 1'b0;
      rstOn    <= 1'b1;
      oeOn     <= 1'b0;
      polReg   <= 1'b0;
      polKnown <= 1'b0;
    end else begin
      if (ctl.capturePol) begin
        polReg   <= rstSense;
        polKnown <= 1'b1;
      end
      if (ctl.setReq)      reqOn <= 1'b1;
      else if (ctl.clrReq) reqOn <= 1'b0;
      if (ctl.setRst)      rstOn <= 1'b1;
      else if (ctl.clrRst) rstOn <= 1'b0;
      if (ctl.setOe)       oeOn  <= 1'b1;
      else if (ctl.clrOe)  oeOn  <= 1'b0;
    end
  end

  // one down-counter serves both the reset pulse and the run delay
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                dlyCnt <= '0;
    else if (ctl.loadPulse)   dlyCnt <= DLY_W'(PULSE_CYC - 1);
    else if (ctl.loadRun)     dlyCnt <= DLY_W'(RUN_CYC - 1);
    else if (dlyCnt != '0)    dlyCnt <= dlyCnt - 1'b1;
  end

  // free-running slow timebase, timeout counted in its ticks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     preCnt <= '0;
    else if (tick) preCnt <= '0;
    else           preCnt <= preCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     toCnt <= '0;
    else if (ctl.loadTimeout)      toCnt <= TO_W'(TIMEOUT_TICKS);
    else if (tick && toCnt != '0)  toCnt <= toCnt - 1'b1;
  end

  assign delayDone   = (dlyCnt == '0);
  assign timeoutDone = (toCnt == '0);
  assign busReqN     = ~reqOn;
  assign rstDrive    = rstOn ? polReg : ~polReg;
  assign rstOe       = polKnown;
  assign addrOe      = oeOn;

endmodule

// File: rtl/cpu_bus_owner_ctrl.sv
module cpu_bus_owner_ctrl
  import cpu_bus_owner_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdCode,
  input  logic       ackN,
  input  logic       delayDone,
  input  logic       timeoutDone,
  output dpCtl_t     ctl,
  output logic [1:0] busState,
  output logic       busy
);

  typedef enum logic [2:0] {
    PH_INIT, PH_IDLE, PH_HOLD, PH_FREE, PH_PULSE, PH_RUNDLY, PH_GRANT, PH_MCFREE
  } phase_t;

  phase_t    phReg, phNext;
  busState_t stReg, stNext, tgtReg, tgtNext;
  logic      reOeReg, reOeNext;

  always_comb begin
    ctl      = '0;
    phNext   = phReg;
    stNext   = stReg;
    tgtNext  = tgtReg;
    reOeNext = reOeReg;
    case (phReg)
      PH_INIT: begin
        ctl.capturePol = 1'b1;
        phNext = PH_IDLE;
      end
      PH_IDLE: if (cmdValid) begin
        case (cmdCode)
          CMD_RESET: begin
            ctl.clrOe = 1'b1; ctl.setRst = 1'b1; ctl.loadPulse = 1'b1;
            tgtNext = ST_RESET; phNext = PH_HOLD;
          end
          CMD_REQUEST: if (!stReg[0]) begin
            ctl.setReq = 1'b1; ctl.loadTimeout = 1'b1;
            ctl.clrRst = (stReg == ST_RESET);
            phNext = PH_GRANT;
          end
          CMD_RELEASE: begin
            if (stReg == ST_RESET_ACQ) begin
              ctl.clrOe = 1'b1; ctl.setRst = 1'b1; ctl.loadPulse = 1'b1;
              tgtNext = ST_RESET; phNext = PH_HOLD;
            end else if (stReg == ST_RUN_ACQ) begin
              ctl.clrOe = 1'b1; ctl.clrReq = 1'b1; ctl.loadTimeout = 1'b1;
              tgtNext = ST_RUN; phNext = PH_FREE;
            end
          end
          CMD_RUN: begin
            if (stReg == ST_RESET) begin
              ctl.loadRun = 1'b1; phNext = PH_RUNDLY;
            end else if (stReg == ST_RESET_ACQ) begin
              ctl.clrOe = 1'b1; ctl.setRst = 1'b1; ctl.loadPulse = 1'b1;
              tgtNext = ST_RUN_ACQ; reOeNext = 1'b1; phNext = PH_PULSE;
            end
          end
          CMD_RESTART: if (stReg[1]) begin
            ctl.setRst = 1'b1; ctl.loadPulse = 1'b1;
            tgtNext = stReg; reOeNext = 1'b0; phNext = PH_PULSE;
          end
          CMD_MCYCLE: if (stReg == ST_RUN_ACQ) begin
            ctl.clrOe = 1'b1; ctl.clrReq = 1'b1; ctl.loadTimeout = 1'b1;
            phNext = PH_MCFREE;
          end
          default: ;
        endcase
      end
      PH_HOLD: if (delayDone) begin
        ctl.clrReq = 1'b1; ctl.loadTimeout = 1'b1;
        phNext = PH_FREE;
      end
      PH_FREE: if (ackN || timeoutDone) begin
        stNext = tgtReg; phNext = PH_IDLE;
      end
      PH_PULSE: if (delayDone) begin
        ctl.clrRst = 1'b1; ctl.setOe = reOeReg;
        stNext = tgtReg; phNext = PH_IDLE;
      end
      PH_RUNDLY: if (delayDone) begin
        ctl.clrRst = 1'b1; stNext = ST_RUN; phNext = PH_IDLE;
      end
      PH_GRANT: begin
        if (!ackN) begin
          ctl.setOe = 1'b1;
          stNext = busState_t'({stReg[1], 1'b1});
          phNext = PH_IDLE;
        end else if (timeoutDone) begin
          ctl.clrReq = 1'b1;
          ctl.setRst = (stReg == ST_RESET);
          stNext = busState_t'({stReg[1], 1'b0});
          phNext = PH_IDLE;
        end
      end
      PH_MCFREE: begin
        if (ackN) begin
          ctl.setReq = 1'b1; ctl.loadTimeout = 1'b1; phNext = PH_GRANT;
        end else if (timeoutDone) begin
          ctl.setReq = 1'b1; ctl.setOe = 1'b1; phNext = PH_IDLE;
        end
      end
      default: phNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phReg   <= PH_INIT;
      stReg   <= ST_RESET;
      tgtReg  <= ST_RESET;
      reOeReg <= 1'b0;
    end else begin
      phReg   <= phNext;
      stReg   <= stNext;
      tgtReg  <= tgtNext;
      reOeReg <= reOeNext;
    end
  end

  assign busState = stReg;
  assign busy     = (phReg != PH_IDLE);

endmodule

// File: rtl/cpu_bus_owner.sv
module cpu_bus_owner
  import cpu_bus_owner_pkg::*;
#(
  parameter int CLK_HZ        = 50000000,
  parameter int PULSE_US      = 10,
  parameter int RUN_US        = 20000,
  parameter int TICK_HZ       = 10,
  parameter int TIMEOUT_TICKS = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdCode,
  input  logic       ackN,
  input  logic       rstSense,
  output logic       busReqN,
  output logic       rstDrive,
  output logic       rstOe,
  output logic       addrOe,
  output logic [1:0] busState,
  output logic       acquired,
  output logic       busy
);

  localparam int CYC_PER_US = CLK_HZ / 1000000;
  localparam int PULSE_CYC  = CYC_PER_US * PULSE_US;
  localparam int RUN_CYC    = CYC_PER_US * RUN_US;
  localparam int TICK_CYC   = CLK_HZ / TICK_HZ;

  dpCtl_t ctl;
  logic   delayDone, timeoutDone;

  cpu_bus_owner_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .ackN(ackN), .delayDone(delayDone), .timeoutDone(timeoutDone),
    .ctl(ctl), .busState(busState), .busy(busy)
  );

  cpu_bus_owner_dp #(
    .PULSE_CYC(PULSE_CYC), .RUN_CYC(RUN_CYC),
    .TICK_CYC(TICK_CYC), .TIMEOUT_TICKS(TIMEOUT_TICKS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rstSense(rstSense),
    .busReqN(busReqN), .rstDrive(rstDrive), .rstOe(rstOe), .addrOe(addrOe),
    .delayDone(delayDone), .timeoutDone(timeoutDone)
  );

  assign acquired = busState[0];

endmodule

// File: rtl/cpu_bus_owner_chk.sv
module cpu_bus_owner_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       cmdValid,
  input logic [1:0] busState,
  input logic       acquired,
  input logic       addrOe,
  input logic       busReqN,
  input logic       rstDrive,
  input logic       polLevel
);

  // R2: when idle, drivers are on exactly when the bus is held
  a_r2_idle_oe_matches: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (addrOe == acquired));

  // R11: drivers are never enabled without an asserted request
  a_r11_oe_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    addrOe |-> !busReqN);

  // R14: idle reset level follows the captured polarity
  a_r14_idle_reset_level: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> ((rstDrive == polLevel) == (busState == 2'd0)));

  // R13: with no command and no sequence, the state holds
  a_r13_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !cmdValid) |=> $stable(busState));

endmodule

bind cpu_bus_owner cpu_bus_owner_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .cmdValid(cmdValid),
  .busState(busState), .acquired(acquired), .addrOe(addrOe),
  .busReqN(busReqN), .rstDrive(rstDrive), .polLevel(u_dp.polReg)
);

// File: tb/cpu_bus_owner_bench.sv
module cpu_bus_owner_bench;

  localparam int PW = 4;   // pulse cycles
  localparam int RD = 12;  // run delay cycles
  localparam int TK = 8;   // tick period cycles
  localparam int TO = 3;   // timeout ticks

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdCode = 3'd0;
  logic rstSense = 1'b1;
  logic ackN;
  logic busReqN, rstDrive, rstOe, addrOe, acquired, busy;
  logic [1:0] busState;

  bit respond = 1'b1;
  logic [1:0] ackPipe = 2'b11;
  logic activeLvl = 1'b1;

  int nChecks = 0, nFails = 0;
  int busyCyc, rstCyc, oeOffCyc, reqLowCyc, reqHighCyc;

  always #10 clk = ~clk;

  // target CPU model: acknowledge follows request two cycles later
  always @(negedge clk) begin
    if (!respond) ackPipe <= 2'b11;
    else          ackPipe <= {ackPipe[0], busReqN};
  end
  assign ackN = ackPipe[1];

  cpu_bus_owner #(
    .CLK_HZ(1000000), .PULSE_US(PW), .RUN_US(RD),
    .TICK_HZ(1000000 / TK), .TIMEOUT_TICKS(TO)
  ) u_cpu_bus_owner (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .ackN(ackN), .rstSense(rstSense), .busReqN(busReqN), .rstDrive(rstDrive),
    .rstOe(rstOe), .addrOe(addrOe), .busState(busState),
    .acquired(acquired), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  task automatic issue(input logic [2:0] c);
    @(negedge clk);
    cmdValid = 1'b1; cmdCode = c;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitIdle();
    busyCyc = 0; rstCyc = 0; oeOffCyc = 0; reqLowCyc = 0; reqHighCyc = 0;
    while (busy) begin
      busyCyc++;
      if (rstDrive == activeLvl) rstCyc++;
      if (!addrOe) oeOffCyc++;
      if (!busReqN) reqLowCyc++;
      else reqHighCyc++;
      @(negedge clk);
    end
  endtask

  task automatic idleCheck(input string tag, input int expSt);
    chk(busState == 2'(expSt), tag, busState, expSt);
    chk(addrOe == busState[0], tag, addrOe, busState[0]);
    chk((rstDrive == activeLvl) == (busState == 2'd0), tag, rstDrive, activeLvl);
  endtask

  function automatic logic [1:0] predict(logic [1:0] s, logic [2:0] c, bit r);
    case (c)
      3'd0: return 2'd0;
      3'd1: if (s == 2'd0) return r ? 2'd1 : 2'd0;
            else if (s == 2'd2) return r ? 2'd3 : 2'd2;
            else return s;
      3'd2: if (s == 2'd1) return 2'd0; else if (s == 2'd3) return 2'd2; else return s;
      3'd3: if (s == 2'd0) return 2'd2; else if (s == 2'd1) return 2'd3; else return s;
      3'd5: if (s == 2'd3) return r ? 2'd3 : 2'd2; else return s;
      default: return s;
    endcase
  endfunction

  task automatic startup(input logic lvl);
    rstN = 1'b0; rstSense = lvl; activeLvl = lvl;
    repeat (3) @(negedge clk);
    chk(busy && !rstOe && busReqN && !addrOe && busState == 2'd0, "R1 in reset",
        {busy, rstOe, busReqN, addrOe}, 4'b1010);
    rstN = 1'b1;
    @(negedge clk);
    chk(rstOe == 1'b1, "R1 rstOe after first edge", rstOe, 1);
    @(negedge clk);
    chk(!busy, "R1 idle", busy, 0);
    chk(rstDrive == lvl, "R14 active level", rstDrive, lvl);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    startup(1'b1);

    // R13: ignored commands in state 0
    issue(3'd4);
    chk(!busy && rstDrive == activeLvl, "R13 restart ignored in 0", busy, 0);
    issue(3'd6);
    chk(!busy && busState == 2'd0, "R13 code 6 ignored", busState, 0);

    // R4: request timeout from 0
    respond = 1'b0;
    issue(3'd1);
    chk(!busReqN && rstDrive != activeLvl, "R3 request edge", busReqN, 0);
    waitIdle();
    chk(busyCyc >= (TO-1)*TK+1 && busyCyc <= TO*TK+1, "R4 timeout length", busyCyc, TO*TK);
    chk(busReqN && rstDrive == activeLvl, "R4 reset back, req dropped", busReqN, 1);
    idleCheck("R4", 0);

    // R3: grant from 0
    respond = 1'b1;
    issue(3'd1); waitIdle();
    idleCheck("R3 grant", 1);

    // R9: run from 1
    issue(3'd3); waitIdle();
    chk(rstCyc == PW, "R9 pulse width", rstCyc, PW);
    chk(oeOffCyc == PW, "R9 drivers off", oeOffCyc, PW);
    idleCheck("R9", 3);

    // R10: restart in 3
    issue(3'd4); waitIdle();
    chk(rstCyc == PW && oeOffCyc == 0, "R10 pulse in 3", rstCyc, PW);
    idleCheck("R10", 3);

    // R11: m-cycle with grant
    issue(3'd5); waitIdle();
    chk(reqHighCyc > 0 && oeOffCyc > 0, "R11 request gap", reqHighCyc, 1);
    idleCheck("R11 regrant", 3);

    // R7: release from 3
    issue(3'd2);
    chk(!addrOe && busReqN && rstDrive != activeLvl, "R7 release edge", addrOe, 0);
    waitIdle();
    idleCheck("R7", 2);

    // R13: run ignored in 2
    issue(3'd3);
    chk(!busy && busState == 2'd2, "R13 run ignored in 2", busState, 2);

    // R10: restart in 2
    issue(3'd4); waitIdle();
    chk(rstCyc == PW, "R10 pulse in 2", rstCyc, PW);
    idleCheck("R10", 2);

    // R5: request from 2, timeout then grant
    respond = 1'b0;
    issue(3'd1); waitIdle();
    idleCheck("R5 timeout", 2);
    respond = 1'b1;
    issue(3'd1); waitIdle();
    idleCheck("R5 grant", 3);

    // R11: m-cycle without regrant
    respond = 1'b0;
    issue(3'd5); waitIdle();
    idleCheck("R11 no regrant", 2);
    respond = 1'b1;

    // R12: reset from 2
    issue(3'd0); waitIdle();
    chk(busReqN && !addrOe, "R12 outputs", busReqN, 1);
    idleCheck("R12", 0);

    // R8 and R13: run delay, command in its last busy cycle is dropped
    @(negedge clk);
    cmdValid = 1'b1; cmdCode = 3'd3;
    @(negedge clk);
    cmdValid = 1'b0;
    repeat (RD - 1) @(negedge clk);
    chk(busy == 1'b1, "R8 still busy", busy, 1);
    cmdValid = 1'b1; cmdCode = 3'd1;
    @(negedge clk);
    cmdValid = 1'b0;
    chk(!busy && rstDrive != activeLvl, "R8 run done after delay", busy, 0);
    @(negedge clk);
    chk(!busy && busReqN && busState == 2'd2, "R13 late request dropped", busState, 2);

    // R6: release from 1
    issue(3'd0); waitIdle();
    issue(3'd1); waitIdle();
    idleCheck("R6 setup", 1);
    issue(3'd2); waitIdle();
    chk(reqLowCyc == PW, "R6 request hold", reqLowCyc, PW);
    idleCheck("R6", 0);

    // R2: random command stream against reference table
    for (int i = 0; i < 200; i++) begin
      logic [2:0] c;
      logic [1:0] exp;
      respond = ($urandom % 4) != 0;
      c = 3'($urandom % 8);
      repeat (2) @(negedge clk);
      exp = predict(busState, c, respond);
      issue(c); waitIdle();
      idleCheck("R2 random", exp);
    end

    // R14: opposite polarity
    startup(1'b0);
    respond = 1'b1;
    issue(3'd1); waitIdle();
    chk(rstDrive == 1'b1, "R14 released at inverse level", rstDrive, 1);
    idleCheck("R14", 1);

    summary();
  end

endmodule